// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator and Checker

This block joins two 8-bit data buses through a direction-controlled transceiver and adds a parity unit that works alongside the data path. A direction input picks the flow. In transmit, the A side is forwarded to the B side. In receive, the B side is forwarded to the A side. An active-low enable can take every driven output off the buses at once. The block is purely combinational.

A single parity line changes role with the direction. In transmit, the block drives it with parity generated from the A data. In receive, the block leaves it undriven and reads it as an incoming parity bit. It then checks that bit against the B data and reports the result on an active-low error output. A select input chooses odd or even parity for both roles.

Each tristate pin is split into a data-in value, a data-out value and an output-enable, so the block stays synthesizable. The chip's pad ring, or a bench, resolves these three signals onto the actual wire.

Top module: `bus_xcvr_par`

## Requirements
- R1: With `oe_n`=0 and `dir_tx`=1 (transmit), `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in`.
- R2: With `oe_n`=0 and `dir_tx`=0 (receive), `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in`.
- R3: With `oe_n`=1, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0 for every value of `dir_tx`.
- R4: In transmit, `par_oe`=1 and `par_out` = `odd_sel` XOR (XOR of the eight `a_in` bits). For example, `odd_sel`=1 with an even number of ones gives `par_out`=1.
- R5: In transmit, `err_oe`=0.
- R6: In receive, `par_oe`=0, `err_oe`=1 and `err_out` = NOT(XOR of `b_in` bits XOR `odd_sel` XOR `par_in`). A 1 on `err_out` means no error. For example, `odd_sel`=1, an even count on B and `par_in`=1 give 1, and an odd count under the same conditions gives 0.
- R7: A count of 0, 2, 4, 6 or 8 ones is treated as even, and a count of 1, 3, 5 or 7 ones is treated as odd.
- R8: Any data, parity or error output whose enable is 0 reads all zeros.
- R9: In receive, `a_in` has no effect on any output. In transmit, `b_in` and `par_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| oe_n | input | 1 | Active-low enable for all driven outputs |
| odd_sel | input | 1 | Parity select used by generator and checker |
| a_in | input | 8 | Value seen on the A bus pins |
| a_out | output | 8 | Value driven onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | 8 | Value seen on the B bus pins |
| b_out | output | 8 | Value driven onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |
| par_in | input | 1 | Value seen on the shared parity pin |
| par_out | output | 1 | Generated parity driven in transmit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_out | output | 1 | Check result, 1 = parity good |
| err_oe | output | 1 | Drive enable for the error pin |

## Verification
Data forwarding and the parity unit act on every input pattern at the same instant. Each vector therefore checks the forwarded bus and the parity or error result together, and also checks that the parity pin's role matches the direction. The bench sweeps all 256 data values under every combination of direction, enable, select and incoming parity. It then runs random vectors with a fixed seed. After each random vector it changes the inputs that should be ignored and requires every output to hold. Expected values come from a popcount model kept in the bench.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef struct packed {
    logic a;
    logic b;
    logic par;
    logic err;
  } drv_en_t;
endpackage

// File: rtl/xcvr_xor_tree.sv
module xcvr_xor_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic         odd
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;
  localparam int P   = 1 << LVL;

  function automatic logic fold(input logic [P-1:0] v);
    logic [P-1:0] cur;
    cur = v;
    for (int s = P / 2; s >= 1; s = s / 2) begin
      for (int i = 0; i < s; i++) begin
        cur[i] = cur[2*i] ^ cur[2*i+1];
      end
    end
    return cur[0];
  endfunction

  generate
    if (W == 1) begin : g_single
      assign odd = din[0];
    end else begin : g_tree
      logic [P-1:0] padded;
      always_comb begin
        padded        = '0;
        padded[W-1:0] = din;
      end
      assign odd = fold(padded);
    end
  endgenerate
endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic    dir_tx,
  input  logic    oe_n,
  output drv_en_t en
);
  logic live;
  assign live = ~oe_n;

  always_comb begin
    en.a   = live & ~dir_tx;
    en.b   = live &  dir_tx;
    en.par = live &  dir_tx;
    en.err = live & ~dir_tx;
  end

  always_comb begin
    a_r3_all_off: assert (!(oe_n && (en.a || en.b || en.par || en.err)))
      else $error("R3 driver active while disabled");
    a_r6_roles_excl: assert (!(en.par && en.err))
      else $error("R6 parity and error both driven");
  end
endmodule

// File: rtl/bus_xcvr_par.sv
module bus_xcvr_par
  import bus_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              dir_tx,
  input  logic              oe_n,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              err_out,
  output logic              err_oe
);
  drv_en_t en;
  logic    a_odd;
  logic    b_odd;

  xcvr_ctrl u_ctrl (.dir_tx(dir_tx), .oe_n(oe_n), .en(en));

  // generator looks at A; checker uses B's input side, never b_out
  xcvr_xor_tree #(.W(DATA_W)) u_gen (.din(a_in), .odd(a_odd));
  xcvr_xor_tree #(.W(DATA_W)) u_chk (.din(b_in), .odd(b_odd));

  assign a_oe   = en.a;
  assign b_oe   = en.b;
  assign par_oe = en.par;
  assign err_oe = en.err;

  always_comb begin
    a_out   = en.a   ? b_in : '0;
    b_out   = en.b   ? a_in : '0;
    par_out = en.par & (odd_sel ^ a_odd);
    err_out = en.err & ~(b_odd ^ odd_sel ^ par_in);
  end

  always_comb begin
    a_r1_bus_excl: assert (!(a_oe && b_oe))
      else $error("R1 both buses driven");
    a_r1_fwd_ab: assert (!b_oe || (b_out == a_in))
      else $error("R1 B does not follow A");
    a_r2_fwd_ba: assert (!a_oe || (a_out == b_in))
      else $error("R2 A does not follow B");
    a_r5_err_quiet_tx: assert (!(dir_tx && err_oe))
      else $error("R5 error driven in transmit");
    a_r8_idle_zero: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0)
                            && (par_oe || !par_out) && (err_oe || !err_out))
      else $error("R8 idle output not zero");
  end
endmodule

// File: tb/bus_xcvr_par_bench.sv
module bus_xcvr_par_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         dir_tx, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_out, err_oe;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  bus_xcvr_par #(.DATA_W(W)) u_bus_xcvr_par (
    .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .err_out(err_out), .err_oe(err_oe)
  );

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic is_odd(input logic [W-1:0] v);
    return (ones(v) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s act=%0h exp=%0h (dir=%0b oe_n=%0b sel=%0b a=%0h b=%0h p=%0b)",
               req, act, exp, dir_tx, oe_n, odd_sel, a_in, b_in, par_in);
    end
  endtask

  task automatic drive(input logic d, input logic o, input logic s,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    @(posedge clk);
    dir_tx = d; oe_n = o; odd_sel = s; a_in = a; b_in = b; par_in = p;
    #(CLK_PERIOD/4);
  endtask

  task automatic verify();
    logic live = ~oe_n;
    logic tx = live & dir_tx;
    logic rx = live & ~dir_tx;
    logic ep = tx & (odd_sel ^ is_odd(a_in));
    logic ee = rx & ~(is_odd(b_in) ^ odd_sel ^ par_in);
    if (oe_n) chk("R3 enables", {a_oe, b_oe, par_oe, err_oe}, 4'b0000);
    chk("R1 b_oe", b_oe, tx);
    chk("R2 a_oe", a_oe, rx);
    if (tx) chk("R1 b_out", b_out, a_in); else chk("R8 b_out idle", b_out, 0);
    if (rx) chk("R2 a_out", a_out, b_in); else chk("R8 a_out idle", a_out, 0);
    chk("R4 par_oe", par_oe, tx);
    chk("R4 R7 par_out", par_out, ep);
    if (dir_tx) chk("R5 err_oe", err_oe, 1'b0);
    chk("R6 err_oe", err_oe, rx);
    chk("R6 R7 err_out", err_out, ee);
  endtask

  initial begin
    logic [W-1:0] sa, sb;
    logic         sp, sep, see;
    void'($urandom(32'h0000_2c4d));
    dir_tx = 0; oe_n = 1; odd_sel = 0; a_in = '0; b_in = '0; par_in = 0;
    #(CLK_PERIOD/4);
    chk("R3 initial enables", {a_oe, b_oe, par_oe, err_oe}, 4'b0000);

    // directed corners (R4, R6, R7 examples)
    drive(1, 0, 1, 8'h00, 8'h00, 0); chk("R4 sel1 zero ones", par_out, 1'b1);
    drive(1, 0, 1, 8'hFF, 8'h00, 0); chk("R7 eight ones even", par_out, 1'b1);
    drive(1, 0, 0, 8'h80, 8'h00, 0); chk("R7 one one odd", par_out, 1'b1);
    drive(0, 0, 1, 8'h00, 8'h03, 1); chk("R6 even good", err_out, 1'b1);
    drive(0, 0, 1, 8'h00, 8'h07, 1); chk("R6 odd error", err_out, 1'b0);
    drive(0, 1, 1, 8'h00, 8'h07, 1); chk("R3 rx disabled", {a_oe, err_oe}, 2'b00);

    // full sweep
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 256; v++) begin
        drive(m[0], m[1], m[2], W'(v), W'(255 - v), m[3]);
        verify();
      end
    end

    // random vectors with ignored-input perturbation (R9)
    for (int k = 0; k < 1500; k++) begin
      drive(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom),
            W'($urandom), W'($urandom), 1'($urandom));
      verify();
      sa = b_out; sb = a_out; sp = par_in; sep = par_out; see = err_out;
      if (dir_tx) begin
        b_in = ~b_in; par_in = ~sp;
      end else begin
        a_in = ~a_in;
      end
      #1;
      chk("R9 a_out held", a_out, sb);
      chk("R9 b_out held", b_out, sa);
      chk("R9 par/err held", {par_out, err_out}, {sep, see});
    end

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errs++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule